// File: doc/BRIEF.md
# Test Data Register Path

This block is the data-register half of a boundary-scan test port. A separate TAP controller supplies one-cycle state strobes (capture, shift, update, test-logic-reset) that are sampled on the rising test clock. The current instruction arrives as a 5-bit opcode. From that opcode the block picks one of three registers to sit between the serial input and the serial output. The first is a 32-bit identification register that reloads a fixed device word on capture. The second is a single-bit bypass register. The third is a single-bit test-control register, which has a parallel hold stage whose output sets the pad drive strength.

The selected register shifts toward its least significant bit, one bit per rising edge, and takes its new top bit from the serial input. The serial output is re-timed on the falling edge and is only valid while its output enable is high. The hold stage changes only on an update strobe under the test-control instruction, or on test-logic-reset.

Top module: `jtag_dr_path`

## Requirements
- R1: The identification word has the revision parameter (default 0) in bits 31:28, 6'b011101 in bits 27:22, the part-number parameter (default 10'h06C) in bits 21:12, 11'h00E in bits 11:1 and 1 in bit 0. With default parameters the word is 32'h0746C01D.
- R2: Opcode 5'h01 selects the identification register. A capture strobe reloads the word, and the next 32 shift cycles present it on `tdo` least significant bit first.
- R3: Opcodes 5'h1F, 5'h05 and 5'h04 all select the bypass register. Capture loads 0, so the first bit out is 0, and each later bit out equals `tdi` from the previous shift cycle.
- R4: Any opcode other than 5'h01, 5'h0D, 5'h1F, 5'h05 and 5'h04 selects the bypass register.
- R5: Opcode 5'h0D selects the 1-bit test-control register. Capture loads the current `drv_sel`, and that register gives a one-cycle `tdi`-to-`tdo` path.
- R6: An update strobe under opcode 5'h0D copies the test-control shift bit to `drv_sel` on that rising edge.
- R7: An update strobe under any other opcode leaves `drv_sel` unchanged.
- R8: `tdo` changes only on falling `tck` edges. It holds its value across the rising edge.
- R9: On each falling edge `tdo_oe` takes the value of `shift_dr`, so it is low in every cycle that is not a shift cycle.
- R10: While `tlr` is high at a clock edge, `drv_sel` clears to 0, `tdo` and `tdo_oe` clear to 0, and the identification register is the selected path whatever the opcode.
- R11: When `tlr` and an update strobe under opcode 5'h0D occur in the same cycle, `drv_sel` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | Test-logic-reset state strobe, active high |
| tdi | input | 1 | Serial data in |
| ir_opcode | input | 5 | Current instruction opcode |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| tdo | output | 1 | Serial data out, re-timed on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| drv_sel | output | 1 | Held test-control bit (drive-strength select) |

## Verification
Two functions can hit the same rising edge: test-logic-reset clearing the hold stage, and an update under the test-control instruction loading it. The bench first shifts a 1 into the test-control register. It then raises `tlr` and `update_dr` together under opcode 5'h0D and requires `drv_sel` to read 0 afterwards. A second overlap comes from raising `tlr` in the middle of an identification readout while `shift_dr` stays high and the opcode names bypass. That cycle must shift the identification register and not the bypass register. The bench judges this from which identification bit appears on `tdo` next.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;

  typedef enum logic [1:0] {
    DR_ID  = 2'd0,
    DR_BYP = 2'd1,
    DR_TC  = 2'd2
  } dr_sel_e;

  localparam int unsigned ID_W    = 32;
  localparam int unsigned REV_W   = 4;
  localparam int unsigned DSGN_W  = 6;
  localparam int unsigned PART_W  = 10;
  localparam int unsigned MFG_W   = 11;

  localparam logic [DSGN_W-1:0] DSGN_CODE = 6'b011101;
  localparam logic [MFG_W-1:0]  MFG_CODE  = 11'h00E;

  // Assemble the fixed identification word from its fields.
  function automatic logic [ID_W-1:0] make_id_word(
    input logic [REV_W-1:0]  rev,
    input logic [PART_W-1:0] part
  );
    return {rev, DSGN_CODE, part, MFG_CODE, 1'b1};
  endfunction

  // Serial step of a register of any width: new top bit from tdi.
  function automatic logic [ID_W-1:0] shift_in(
    input logic [ID_W-1:0] cur,
    input logic            din,
    input int unsigned     width
  );
    logic [ID_W-1:0] nxt;
    nxt = cur >> 1;
    nxt[width-1] = din;
    return nxt;
  endfunction

endpackage

// File: rtl/jtag_dr_decode.sv
module jtag_dr_decode
  import jtag_dr_pkg::*;
#(
  parameter int unsigned      IR_W      = 5,
  parameter logic [IR_W-1:0]  OP_ID     = 5'h01,
  parameter logic [IR_W-1:0]  OP_TC     = 5'h0D,
  parameter logic [IR_W-1:0]  OP_BYPASS = 5'h1F,
  parameter logic [IR_W-1:0]  OP_CLAMP  = 5'h05,
  parameter logic [IR_W-1:0]  OP_HIGHZ  = 5'h04
) (
  input  logic [IR_W-1:0] opcode,
  input  logic            force_id,
  output dr_sel_e         sel
);

  dr_sel_e raw_sel;

  always_comb begin
    if (opcode == OP_ID)      raw_sel = DR_ID;
    else if (opcode == OP_TC) raw_sel = DR_TC;
    else if (opcode == OP_BYPASS || opcode == OP_CLAMP ||
             opcode == OP_HIGHZ)
                              raw_sel = DR_BYP;
    else                      raw_sel = DR_BYP;
  end

  assign sel = force_id ? DR_ID : raw_sel;

endmodule

// File: rtl/jtag_dr_shreg.sv
module jtag_dr_shreg #(
  parameter int unsigned W = 1
) (
  input  logic         tck,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic         din,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);

  generate
    if (W == 1) begin : g_bit
      always_ff @(posedge tck) begin
        if (cap_en)     q <= cap_val;
        else if (sh_en) q <= din;
      end
    end else begin : g_vec
      always_ff @(posedge tck) begin
        if (cap_en)     q <= cap_val;
        else if (sh_en) q <= {din, q[W-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/jtag_dr_hold.sv
module jtag_dr_hold (
  input  logic tck,
  input  logic clr,
  input  logic upd_en,
  input  logic d,
  output logic q
);

  always_ff @(posedge tck) begin
    if (clr)         q <= 1'b0;
    else if (upd_en) q <= d;
  end

endmodule

// File: rtl/jtag_dr_path.sv
module jtag_dr_path
  import jtag_dr_pkg::*;
#(
  parameter int unsigned       IR_W      = 5,
  parameter logic [REV_W-1:0]  REV_NUM   = 4'h0,
  parameter logic [PART_W-1:0] PART_NUM  = 10'h06C,
  parameter logic [IR_W-1:0]   OP_ID     = 5'h01,
  parameter logic [IR_W-1:0]   OP_TC     = 5'h0D,
  parameter logic [IR_W-1:0]   OP_BYPASS = 5'h1F,
  parameter logic [IR_W-1:0]   OP_CLAMP  = 5'h05,
  parameter logic [IR_W-1:0]   OP_HIGHZ  = 5'h04
) (
  input  logic            tck,
  input  logic            tlr,
  input  logic            tdi,
  input  logic [IR_W-1:0] ir_opcode,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  output logic            tdo,
  output logic            tdo_oe,
  output logic            drv_sel
);

  localparam logic [ID_W-1:0] ID_VALUE = make_id_word(REV_NUM, PART_NUM);

  dr_sel_e         cur_sel;
  logic            sel_id, sel_byp, sel_tc;
  logic [ID_W-1:0] id_word;
  logic            byp_bit;
  logic            tc_bit;
  logic            tc_update;
  logic            serial_out;

  jtag_dr_decode #(
    .IR_W(IR_W), .OP_ID(OP_ID), .OP_TC(OP_TC),
    .OP_BYPASS(OP_BYPASS), .OP_CLAMP(OP_CLAMP), .OP_HIGHZ(OP_HIGHZ)
  ) u_dec (
    .opcode  (ir_opcode),
    .force_id(tlr),
    .sel     (cur_sel)
  );

  assign sel_id    = (cur_sel == DR_ID);
  assign sel_byp   = (cur_sel == DR_BYP);
  assign sel_tc    = (cur_sel == DR_TC);
  assign tc_update = update_dr && sel_tc;

  jtag_dr_shreg #(.W(ID_W)) u_id (
    .tck(tck), .cap_en(capture_dr && sel_id), .sh_en(shift_dr && sel_id),
    .din(tdi), .cap_val(ID_VALUE), .q(id_word)
  );

  jtag_dr_shreg #(.W(1)) u_byp (
    .tck(tck), .cap_en(capture_dr && sel_byp), .sh_en(shift_dr && sel_byp),
    .din(tdi), .cap_val(1'b0), .q(byp_bit)
  );

  jtag_dr_shreg #(.W(1)) u_tc (
    .tck(tck), .cap_en(capture_dr && sel_tc), .sh_en(shift_dr && sel_tc),
    .din(tdi), .cap_val(drv_sel), .q(tc_bit)
  );

  jtag_dr_hold u_hold (
    .tck(tck), .clr(tlr), .upd_en(tc_update), .d(tc_bit), .q(drv_sel)
  );

  always_comb begin
    unique case (cur_sel)
      DR_ID:   serial_out = id_word[0];
      DR_TC:   serial_out = tc_bit;
      default: serial_out = byp_bit;
    endcase
  end

  always_ff @(negedge tck) begin
    if (tlr) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shift_dr;
      if (shift_dr) tdo <= serial_out;
    end
  end

endmodule

module jtag_dr_path_chk
  import jtag_dr_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0746C01D
) (
  input logic            tck,
  input logic            tlr,
  input logic            capture_dr,
  input logic            shift_dr,
  input logic            update_dr,
  input logic            tdo_oe,
  input logic            drv_sel,
  input logic            sel_id,
  input logic            sel_byp,
  input logic            sel_tc,
  input logic            tc_bit,
  input logic            byp_bit,
  input logic [ID_W-1:0] id_word
);

  p_one_path_r4: assert property (@(posedge tck) disable iff (tlr)
    $countones({sel_id, sel_byp, sel_tc}) == 1);

  p_id_capture_r2: assert property (@(posedge tck) disable iff (tlr)
    (capture_dr && sel_id) |=> (id_word == ID_VALUE));

  p_byp_capture_r3: assert property (@(posedge tck) disable iff (tlr)
    (capture_dr && sel_byp) |=> (byp_bit == 1'b0));

  p_hold_load_r6: assert property (@(posedge tck) disable iff (tlr)
    (update_dr && sel_tc) |=> (drv_sel == $past(tc_bit)));

  p_hold_keep_r7: assert property (@(posedge tck) disable iff (tlr)
    !(update_dr && sel_tc) |=> $stable(drv_sel));

  p_oe_tracks_shift_r9: assert property (@(posedge tck) disable iff (tlr)
    tdo_oe == shift_dr);

  p_tlr_clears_r10: assert property (@(posedge tck)
    tlr |=> (drv_sel == 1'b0));

endmodule

bind jtag_dr_path jtag_dr_path_chk #(.ID_VALUE(ID_VALUE)) u_chk (
  .tck(tck), .tlr(tlr), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .update_dr(update_dr), .tdo_oe(tdo_oe), .drv_sel(drv_sel),
  .sel_id(sel_id), .sel_byp(sel_byp), .sel_tc(sel_tc),
  .tc_bit(tc_bit), .byp_bit(byp_bit), .id_word(id_word)
);

// File: tb/jtag_dr_path_bench.sv
module jtag_dr_path_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EXP_ID = {4'h0, 6'b011101, 10'h06C, 11'h00E, 1'b1};

  // Each row: {opcode[12:8], tdi pattern[7:0]}
  localparam int NVEC = 9;
  localparam logic [12:0] VEC [NVEC] = '{
    {5'h01, 8'hA5}, {5'h1F, 8'h5A}, {5'h05, 8'hC3}, {5'h04, 8'h0F},
    {5'h00, 8'hF0}, {5'h12, 8'h99}, {5'h0D, 8'h6E}, {5'h1E, 8'h81},
    {5'h01, 8'h00}
  };

  logic       tck = 1'b0;
  logic       tlr, tdi, capture_dr, shift_dr, update_dr;
  logic [4:0] ir_opcode;
  logic       tdo, tdo_oe, drv_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  bit tdo_moved = 0;

  always #(CLK_PERIOD/2) tck = ~tck;

  jtag_dr_path u_jtag_dr_path (
    .tck(tck), .tlr(tlr), .tdi(tdi), .ir_opcode(ir_opcode),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdo(tdo), .tdo_oe(tdo_oe), .drv_sel(drv_sel)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock cycle: drive strobes, sample tdo after the falling edge,
  // then confirm tdo does not move across the rising edge (R8).
  task automatic cyc(input logic r, input logic c, input logic s,
                     input logic u, input logic d,
                     output logic tdo_s, output logic oe_s);
    tlr = r; capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
    @(negedge tck); #1;
    tdo_s = tdo; oe_s = tdo_oe;
    @(posedge tck); #1;
    if (tdo !== tdo_s) tdo_moved = 1;
  endtask

  function automatic logic [7:0] exp_bits(input logic [4:0] op,
                                          input logic [7:0] pat,
                                          input logic held);
    if (op == 5'h01) return EXP_ID[7:0];
    if (op == 5'h0D) return {pat[6:0], held};
    return {pat[6:0], 1'b0};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic t, o;
    logic [7:0]  got8;
    logic [31:0] got32;
    bit oe_ok;

    ir_opcode = 5'h1F;
    // R10: reset state
    cyc(1, 0, 0, 0, 0, t, o);
    cyc(1, 0, 0, 0, 0, t, o);
    check(drv_sel === 1'b0, "R10 reset drv_sel", {31'd0, drv_sel}, 0);
    check(tdo_oe === 1'b0 && tdo === 1'b0, "R10 reset tdo/oe",
          {30'd0, tdo, tdo_oe}, 0);

    // Table walk: R2, R3, R4, R5, R9
    for (int i = 0; i < NVEC; i++) begin
      ir_opcode = VEC[i][12:8];
      cyc(0, 1, 0, 0, 0, t, o);
      oe_ok = (o === 1'b0);
      for (int b = 0; b < 8; b++) begin
        cyc(0, 0, 1, 0, VEC[i][b], t, o);
        got8[b] = t;
        if (o !== 1'b1) oe_ok = 0;
      end
      cyc(0, 0, 0, 0, 0, t, o);
      if (o !== 1'b0) oe_ok = 0;
      check(got8 === exp_bits(VEC[i][12:8], VEC[i][7:0], 1'b0),
            "R2/R3/R4/R5 serial path", {24'd0, got8},
            {24'd0, exp_bits(VEC[i][12:8], VEC[i][7:0], 1'b0)});
      check(oe_ok, "R9 output enable", {31'd0, oe_ok}, 1);
    end
    check(!tdo_moved, "R8 tdo stable over rising edge", {31'd0, tdo_moved}, 0);

    // R1/R2: full identification word
    ir_opcode = 5'h01;
    cyc(0, 1, 0, 0, 0, t, o);
    for (int b = 0; b < 32; b++) begin
      cyc(0, 0, 1, 0, 1'b0, t, o);
      got32[b] = t;
    end
    check(got32 === EXP_ID, "R1 identification word", got32, EXP_ID);

    // R6: load 1 under test-control
    ir_opcode = 5'h0D;
    cyc(0, 1, 0, 0, 0, t, o);
    cyc(0, 0, 1, 0, 1, t, o);
    cyc(0, 0, 0, 1, 0, t, o);
    check(drv_sel === 1'b1, "R6 hold update", {31'd0, drv_sel}, 1);

    // R5: capture loads the held bit
    cyc(0, 1, 0, 0, 0, t, o);
    cyc(0, 0, 1, 0, 0, t, o);
    check(t === 1'b1, "R5 capture of held bit", {31'd0, t}, 1);

    // R7: update under bypass and under identification leaves hold
    ir_opcode = 5'h1F;
    cyc(0, 1, 0, 0, 0, t, o);
    cyc(0, 0, 1, 0, 0, t, o);
    cyc(0, 0, 0, 1, 0, t, o);
    ir_opcode = 5'h01;
    cyc(0, 0, 0, 1, 0, t, o);
    check(drv_sel === 1'b1, "R7 hold unchanged", {31'd0, drv_sel}, 1);

    // R11: tlr and test-control update in the same cycle
    ir_opcode = 5'h0D;
    cyc(0, 1, 0, 0, 0, t, o);
    cyc(0, 0, 1, 0, 1, t, o);
    cyc(1, 0, 0, 1, 0, t, o);
    check(drv_sel === 1'b0, "R11 reset beats update", {31'd0, drv_sel}, 0);

    // R10: forced identification path during tlr while shifting
    ir_opcode = 5'h01;
    cyc(0, 1, 0, 0, 0, t, o);
    for (int b = 0; b < 4; b++) cyc(0, 0, 1, 0, 0, t, o);
    ir_opcode = 5'h1F;
    cyc(1, 0, 1, 0, 0, t, o);
    check(t === 1'b0 && o === 1'b0, "R10 tdo/oe cleared in tlr",
          {30'd0, t, o}, 0);
    ir_opcode = 5'h01;
    cyc(0, 0, 1, 0, 0, t, o);
    check(t === EXP_ID[5], "R10 forced identification shift",
          {31'd0, t}, {31'd0, EXP_ID[5]});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule